// File: doc/BRIEF.md
# DMA Channel Request Gate with Post-Write Wait States

This block is the request front end of one DMA channel that moves data from memory to a peripheral. A two-bit source field picks one of four hardware request lines: an external request pin, a serial-port receive request, a serial-port transmit request, or a disk-interface request. The chosen line reaches the channel's transfer engine as a single gated request.

When the channel runs without a handshake, each write of one peripheral-width item is followed by a programmable blanking window. During this window all requests are ignored, which gives the peripheral time to drop its request line. The window starts on the write acknowledge. For the three internal sources, that acknowledge comes from the system bus. For the external source, it comes from the memory controller. A write to the channel control register ends the window early.

The block also produces a level-sensitive next-buffer interrupt. This interrupt is set only when the buffer state machine enters its buffer-on state while the interrupt enable is 1. It stays set until software clears it. The buffer state and both acknowledge strobes come in as inputs.

Top module: `dma_req_gate`

## Requirements
- R1: With no stall active, `req_out` follows the request line picked by `cfg_src_sel`. The encodings are 2'b00 = `req_ext`, 2'b01 = `req_ser_rx`, 2'b10 = `req_ser_tx` and 2'b11 = `req_disk`. The unselected lines have no effect.
- R2: `stall_busy` is high only when `cfg_no_hs` is 1 and the wait counter is nonzero. While `stall_busy` is high, `req_out` is 0 whatever the selected line does.
- R3: With `cfg_no_hs` = 1, a write acknowledge sampled at a clock edge makes `stall_busy` high for exactly `cfg_wait` cycles. These cycles start right after that edge.
- R4: When `cfg_wait` is 0, an acknowledge applies no masking. The selected request is passed in the cycle after the acknowledge.
- R5: The acknowledge used is `ack_mem` when `cfg_src_sel` is 2'b00, and `ack_bus` for any other source. The other strobe starts no stall.
- R6: With `cfg_no_hs` = 0, acknowledges never raise `stall_busy`.
- R7: A one-cycle `ctrl_wr` pulse clears a running stall at the next edge. It also wins over an acknowledge that arrives in the same cycle.
- R8: An acknowledge that arrives while the counter is running reloads the counter to `cfg_wait`.
- R9: When `buf_on` rises and `cfg_nb_irq_en` is 1, `nb_irq` is set at the next edge.
- R10: `nb_irq` is not set when `cfg_nb_irq_en` is 0 at entry. It is also not set by `buf_on` staying high; only entry sets it.
- R11: `nb_irq` holds until an `irq_clr` pulse. An entry in the same cycle as the clear wins, and the flag stays set.
- R12: After reset, `stall_busy` and `nb_irq` are 0, and `req_out` follows the selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_src_sel | input | 2 | Request source select |
| cfg_no_hs | input | 1 | No-handshake mode: enables post-write blanking |
| cfg_wait | input | WAIT_W | Blanking length in clock cycles |
| cfg_nb_irq_en | input | 1 | Next-buffer interrupt enable |
| ctrl_wr | input | 1 | Pulse for a write to the channel control register; cancels the stall |
| req_ext | input | 1 | External request line |
| req_ser_rx | input | 1 | Serial-port receive request |
| req_ser_tx | input | 1 | Serial-port transmit request |
| req_disk | input | 1 | Disk-interface request |
| ack_bus | input | 1 | Bus write-complete strobe (internal sources) |
| ack_mem | input | 1 | Memory-controller write acknowledge (external source) |
| buf_on | input | 1 | Buffer state machine is in buffer-on state |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| req_out | output | 1 | Gated request to the transfer engine |
| stall_busy | output | 1 | Blanking window active |
| nb_irq | output | 1 | Next-buffer interrupt flag |

## Verification
A wrong counter value shows up as a blanking window of the wrong length. It becomes visible on `stall_busy` and `req_out` within `cfg_wait` + 1 cycles of the acknowledge, so the bench measures the window length for every small wait count. A mis-decoded source or a swapped acknowledge strobe shows up at once as the wrong request passing, or as a missing window. A bad entry-detect register or bad clear priority shows on `nb_irq` one edge after the triggering cycle.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    SRC_EXT    = 2'b00,
    SRC_SER_RX = 2'b01,
    SRC_SER_TX = 2'b10,
    SRC_DISK   = 2'b11
  } req_src_e;

  localparam int NUM_SRC = 4;

  // Internal sources take their write acknowledge from the bus.
  function automatic logic src_uses_bus_ack(input logic [1:0] sel);
    return sel != SRC_EXT;
  endfunction
endpackage

// File: rtl/req_src_mux.sv
module req_src_mux
  import dma_req_pkg::*;
(
  input  logic [1:0]         sel,
  input  logic [NUM_SRC-1:0] req_vec,
  input  logic               ack_bus,
  input  logic               ack_mem,
  output logic               sel_req,
  output logic               ack_evt
);
  logic [NUM_SRC-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      assign hit[g] = (sel == g[1:0]) & req_vec[g];
    end
  endgenerate

  assign sel_req = |hit;
  assign ack_evt = src_uses_bus_ack(sel) ? ack_bus : ack_mem;
endmodule

// File: rtl/wait_stall_counter.sv
module wait_stall_counter #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              no_hs,
  input  logic [WAIT_W-1:0] wait_len,
  input  logic              load,
  input  logic              cancel,
  output logic              busy
);
  logic [WAIT_W-1:0] cnt_q;

  // Cancel beats load; load (also mid-count) restarts; else count down to 0.
  function automatic logic [WAIT_W-1:0] next_cnt(
    input logic [WAIT_W-1:0] cur,
    input logic              ld,
    input logic              cn,
    input logic [WAIT_W-1:0] len
  );
    if (cn)                 return '0;
    else if (ld)            return len;
    else if (cur != '0)     return cur - 1'b1;
    else                    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, load & no_hs, cancel, wait_len);
  end

  assign busy = no_hs & (cnt_q != '0);
endmodule

// File: rtl/nb_irq_gate.sv
module nb_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_on,
  input  logic irq_en,
  input  logic irq_clr,
  output logic entry,
  output logic irq
);
  logic buf_on_q;

  assign entry = buf_on & ~buf_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_on_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      buf_on_q <= buf_on;
      if (entry && irq_en) irq <= 1'b1;
      else if (irq_clr)    irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_req_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_src_sel,
  input  logic              cfg_no_hs,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_nb_irq_en,
  input  logic              ctrl_wr,
  input  logic              req_ext,
  input  logic              req_ser_rx,
  input  logic              req_ser_tx,
  input  logic              req_disk,
  input  logic              ack_bus,
  input  logic              ack_mem,
  input  logic              buf_on,
  input  logic              irq_clr,
  output logic              req_out,
  output logic              stall_busy,
  output logic              nb_irq
);
  logic [NUM_SRC-1:0] req_vec;
  logic               sel_req;
  logic               ack_evt;
  logic               nb_entry;

  assign req_vec = {req_disk, req_ser_tx, req_ser_rx, req_ext};

  req_src_mux u_mux (
    .sel     (cfg_src_sel),
    .req_vec (req_vec),
    .ack_bus (ack_bus),
    .ack_mem (ack_mem),
    .sel_req (sel_req),
    .ack_evt (ack_evt)
  );

  wait_stall_counter #(.WAIT_W(WAIT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .no_hs    (cfg_no_hs),
    .wait_len (cfg_wait),
    .load     (ack_evt),
    .cancel   (ctrl_wr),
    .busy     (stall_busy)
  );

  nb_irq_gate u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .buf_on  (buf_on),
    .irq_en  (cfg_nb_irq_en),
    .irq_clr (irq_clr),
    .entry   (nb_entry),
    .irq     (nb_irq)
  );

  assign req_out = sel_req & ~stall_busy;
endmodule

// File: rtl/dma_req_gate_chk.sv
module dma_req_gate_chk #(
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_src_sel,
  input logic              cfg_no_hs,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              cfg_nb_irq_en,
  input logic              ctrl_wr,
  input logic              req_ext,
  input logic              req_ser_rx,
  input logic              req_ser_tx,
  input logic              req_disk,
  input logic              ack_evt,
  input logic              nb_entry,
  input logic              irq_clr,
  input logic              req_out,
  input logic              stall_busy,
  input logic              nb_irq
);
  logic line_pick;
  always_comb begin
    case (cfg_src_sel)
      2'b00:   line_pick = req_ext;
      2'b01:   line_pick = req_ser_rx;
      2'b10:   line_pick = req_ser_tx;
      default: line_pick = req_disk;
    endcase
  end

  AST_REQ_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> line_pick); // R1
  AST_BUSY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall_busy |-> !req_out); // R2
  AST_ACK_STARTS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && cfg_no_hs && !ctrl_wr && cfg_wait != '0) |=> stall_busy); // R3
  AST_ZERO_WAIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && cfg_no_hs && cfg_wait == '0) |=> !stall_busy); // R4
  AST_HS_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_no_hs |-> !stall_busy); // R6
  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !stall_busy); // R7
  AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_entry && cfg_nb_irq_en) |=> nb_irq); // R9
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nb_irq && !(nb_entry && cfg_nb_irq_en)) |=> !nb_irq); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_irq && !irq_clr) |=> nb_irq); // R11
endmodule

bind dma_req_gate dma_req_gate_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_src_sel   (cfg_src_sel),
  .cfg_no_hs     (cfg_no_hs),
  .cfg_wait      (cfg_wait),
  .cfg_nb_irq_en (cfg_nb_irq_en),
  .ctrl_wr       (ctrl_wr),
  .req_ext       (req_ext),
  .req_ser_rx    (req_ser_rx),
  .req_ser_tx    (req_ser_tx),
  .req_disk      (req_disk),
  .ack_evt       (ack_evt),
  .nb_entry      (nb_entry),
  .irq_clr       (irq_clr),
  .req_out       (req_out),
  .stall_busy    (stall_busy),
  .nb_irq        (nb_irq)
);

// File: tb/tb_dma_req_gate.sv
module tb_dma_req_gate;
  localparam int WAIT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_src_sel = 2'b00;
  logic cfg_no_hs = 1'b0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic cfg_nb_irq_en = 1'b0;
  logic ctrl_wr = 1'b0;
  logic req_ext = 1'b0, req_ser_rx = 1'b0, req_ser_tx = 1'b0, req_disk = 1'b0;
  logic ack_bus = 1'b0, ack_mem = 1'b0;
  logic buf_on = 1'b0, irq_clr = 1'b0;
  logic req_out, stall_busy, nb_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_req_gate #(.WAIT_W(WAIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_src_sel(cfg_src_sel), .cfg_no_hs(cfg_no_hs),
    .cfg_wait(cfg_wait), .cfg_nb_irq_en(cfg_nb_irq_en), .ctrl_wr(ctrl_wr),
    .req_ext(req_ext), .req_ser_rx(req_ser_rx), .req_ser_tx(req_ser_tx),
    .req_disk(req_disk), .ack_bus(ack_bus), .ack_mem(ack_mem), .buf_on(buf_on),
    .irq_clr(irq_clr), .req_out(req_out), .stall_busy(stall_busy), .nb_irq(nb_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All driving and sampling happens 1 ns after a rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_reqs(input logic [3:0] v);
    {req_disk, req_ser_tx, req_ser_rx, req_ext} = v;
  endtask

  task automatic pulse_ack(input logic use_bus);
    if (use_bus) ack_bus = 1'b1; else ack_mem = 1'b1;
    tick();
    ack_bus = 1'b0;
    ack_mem = 1'b0;
  endtask

  // Counts consecutive busy cycles, starting at the current sample point.
  task automatic measure_busy(output int n);
    n = 0;
    while (stall_busy && n < 300) begin
      n++;
      tick();
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R12: reset state
    chk("R12 stall_busy after reset", stall_busy, 0);
    chk("R12 nb_irq after reset", nb_irq, 0);
    set_reqs(4'b0001);
    #1 chk("R12 req passes after reset", req_out, 1);

    // R1: full sweep of select x request patterns
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 16; p++) begin
        cfg_src_sel = s[1:0];
        set_reqs(p[3:0]);
        #1 chk($sformatf("R1 sel=%0d pat=%0h", s, p), req_out, (p >> s) & 1);
      end
    end
    set_reqs(4'b0000);

    // R3/R4: window length sweep, external (mem ack) and internal (bus ack)
    cfg_no_hs = 1'b1;
    for (int src = 0; src < 2; src++) begin
      cfg_src_sel = (src == 0) ? 2'b00 : 2'b11;
      for (int w = 0; w < 8; w++) begin
        cfg_wait = w[WAIT_W-1:0];
        pulse_ack(src == 1);
        measure_busy(n);
        chk($sformatf("R3 window src=%0d wait=%0d", src, w), n, w);
        tick();
      end
    end

    // R4: zero wait, request passes in the cycle after the ack
    cfg_src_sel = 2'b01; cfg_wait = '0;
    set_reqs(4'b0010);
    pulse_ack(1'b1);
    chk("R4 zero wait request passes", req_out, 1);
    set_reqs(4'b0000);

    // R2: request masked while busy
    cfg_wait = 8'd4;
    pulse_ack(1'b1);
    set_reqs(4'b0010);
    #1 chk("R2 masked while busy", req_out, 0);
    chk("R2 busy during window", stall_busy, 1);
    measure_busy(n);
    chk("R2 request passes after window", req_out, 1);
    set_reqs(4'b0000);

    // R5: wrong acknowledge starts nothing
    cfg_src_sel = 2'b00;
    pulse_ack(1'b1);
    chk("R5 ext ignores bus ack", stall_busy, 0);
    cfg_src_sel = 2'b10;
    pulse_ack(1'b0);
    chk("R5 internal ignores mem ack", stall_busy, 0);

    // R6: handshake mode never stalls
    cfg_no_hs = 1'b0;
    pulse_ack(1'b1);
    chk("R6 no stall with handshake", stall_busy, 0);
    set_reqs(4'b0100);
    #1 chk("R6 request passes with handshake", req_out, 1);
    set_reqs(4'b0000);
    cfg_no_hs = 1'b1;

    // R8: reload mid-count
    cfg_wait = 8'd5;
    pulse_ack(1'b1);
    tick(); tick();
    pulse_ack(1'b1);
    measure_busy(n);
    chk("R8 reload gives full window", n, 5);
    tick();

    // R7: cancel mid-count, and cancel beats a simultaneous ack
    cfg_wait = 8'd6;
    pulse_ack(1'b1);
    tick();
    ctrl_wr = 1'b1;
    tick();
    ctrl_wr = 1'b0;
    chk("R7 cancel clears stall", stall_busy, 0);
    ctrl_wr = 1'b1; ack_bus = 1'b1;
    tick();
    ctrl_wr = 1'b0; ack_bus = 1'b0;
    chk("R7 cancel beats ack", stall_busy, 0);

    // R9: entry with enable sets flag
    cfg_nb_irq_en = 1'b1;
    buf_on = 1'b1;
    tick();
    chk("R9 irq set on entry", nb_irq, 1);
    // R11: holds, then clears
    tick(); tick();
    chk("R11 irq holds", nb_irq, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R11 irq cleared", nb_irq, 0);
    // R10: staying in buffer-on does not re-set
    tick(); tick();
    chk("R10 no re-set while buffer-on held", nb_irq, 0);
    // R10: entry with enable low
    buf_on = 1'b0; tick();
    cfg_nb_irq_en = 1'b0;
    buf_on = 1'b1; tick(); tick();
    chk("R10 no irq when disabled", nb_irq, 0);
    // R11: entry beats simultaneous clear
    buf_on = 1'b0; cfg_nb_irq_en = 1'b1; tick();
    buf_on = 1'b1; irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R11 entry beats clear", nb_irq, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule